// File: doc/BRIEF.md
# Magnet circuit interlock sequencer

This block guards one powered circuit made of several water-cooled magnets. It watches current-loop status lines in which a 1 means the loop carries current and all is well, and a 0 (including a dead supply) means trouble. The lines are two thermal-switch chains per magnet, a cable-presence line per magnet, a cable-presence line for the converter and a failure line from the converter. Every line is first brought into the clock domain and then debounced.

When a fault survives the debounce, the block drops its beam-dump flag at once. It keeps the converter permit up for a programmable hold time, about one second by default, so that the beam is gone before the magnet current starts to decay. After that it removes the permit and stays locked out until a rearm pulse arrives while every line is healthy. A self-test output can open a chosen magnet's thermal loop from the control room to prove the trip chain works. It is refused whenever the operation-mode line is high.

Top module: `magnet_interlock_seq`

## Requirements
- R1: Reset puts the sequencer in lockout with `pcPermit` 0 and `beamOk` 0. `stateOut` encodes run as 0, dump-wait as 1, lockout as 2 and self-test as 3.
- R2: A 0 on any of these lines is a fault: a thermal chain (`tempLoopA`, or `tempLoopB` when `DUAL_TEMP` is 1), a magnet cable line, the converter cable line or the converter failure line. Each of these is handled the same way.
- R3: Every input passes two synchronizing flip-flops and a debounce filter. A new level takes effect `2+FILT_LEN` clock edges after it is applied. A level that lasts fewer than `FILT_LEN` cycles has no effect.
- R4: `beamOk` goes to 0 in the same cycle in which a debounced fault first appears. `pcPermit` is unchanged in that cycle.
- R5: After the fault cycle, the sequencer sits in dump-wait for exactly `DUMP_DELAY` cycles with `pcPermit` held. It then enters lockout with `pcPermit` 0.
- R6: Lockout holds until a one-cycle `rearm` pulse arrives while every debounced status line and the powering permit are 1. A rearm pulse at any other time is ignored.
- R7: `pcPermit` is 1 only outside lockout and only while the debounced `powerPermit` is 1. Losing `powerPermit` clears `pcPermit` but leaves `beamOk` at 1 and the state at run.
- R8: `testOpen` is nonzero only in self-test. It is forced to 0 in any cycle where the raw `opMode` is 1. Self-test is entered from run when `testReq` is nonzero and the debounced `opMode` is 0. It is left back to run when `testReq` returns to 0 or the debounced `opMode` becomes 1.
- R9: A loop opened by self-test takes the normal fault path: `beamOk` drops, then dump-wait runs, then lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempLoopA | input | NUM_MAG | First thermal-switch chain per magnet, 1 = cool |
| tempLoopB | input | NUM_MAG | Redundant thermal chain per magnet, used when DUAL_TEMP is 1 |
| magCableOk | input | NUM_MAG | Magnet cable present, 1 = connected |
| pcCableOk | input | 1 | Converter cable present, 1 = connected |
| pcFailLoop | input | 1 | Converter failure loop, 0 = converter off or tripping |
| powerPermit | input | 1 | Upstream permission to power the circuit |
| opMode | input | 1 | Machine in operation, 1 = self-test forbidden |
| testReq | input | NUM_MAG | Self-test request, one bit per magnet |
| rearm | input | 1 | Synchronous one-cycle pulse that leaves lockout |
| beamOk | output | 1 | Circuit-healthy flag to beam-dump logic, 0 = dump |
| pcPermit | output | 1 | Converter run permit |
| testOpen | output | NUM_MAG | Opens the selected magnet thermal loop |
| stateOut | output | 2 | Sequencer state code |

## Verification
The bench builds the block with three magnets and both thermal chains enabled, a debounce of 4 cycles and a dump hold of 40 cycles. These values make the full trip, hold, lockout and rearm cycle short enough to repeat for each kind of status line. With a 4-cycle filter, a 3-cycle glitch and a full-length fault can be told apart at exact edges. The 40-cycle hold lets the bench pin the permit drop to the exact cycle, both for a real fault and for one caused by self-test.

// File: rtl/mcis_pkg.sv
package mcis_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_DUMPWAIT = 2'd1,
    ST_LOCKOUT  = 2'd2,
    ST_SELFTEST = 2'd3
  } seqState_t;

  typedef struct packed {
    logic timerRun;
    logic permitHold;
    logic beamGate;
    logic testDrive;
  } ctl_t;

endpackage

// File: rtl/mcis_datapath.sv
module mcis_datapath
  import mcis_pkg::*;
#(
  parameter int NUM_MAG    = 4,
  parameter int FILT_LEN   = 16,
  parameter int DUMP_DELAY = 250_000_000,
  parameter bit DUAL_TEMP  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_MAG-1:0] tempLoopA,
  input  logic [NUM_MAG-1:0] tempLoopB,
  input  logic [NUM_MAG-1:0] magCableOk,
  input  logic               pcCableOk,
  input  logic               pcFailLoop,
  input  logic               powerPermit,
  input  logic               opMode,
  input  logic [NUM_MAG-1:0] testReq,
  input  ctl_t               ctl,
  output logic               faultSeen,
  output logic               powerOk,
  output logic               opModeF,
  output logic               timerDone,
  output logic               beamOk,
  output logic               pcPermit,
  output logic [NUM_MAG-1:0] testOpen
);

  localparam int NLOOP = 3 * NUM_MAG + 2;
  localparam int NIN   = NLOOP + 2;
  localparam int CW    = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam int TW    = $clog2(DUMP_DELAY + 1);

  logic [NUM_MAG-1:0] tempB;
  logic [NIN-1:0]     rawIn;
  logic [NIN-1:0]     filt;
  logic [TW-1:0]      tmr;

  // Redundant chain in use, or tied healthy for single-chain magnets
  generate
    if (DUAL_TEMP) begin : gDual
      assign tempB = tempLoopB;
    end else begin : gSingle
      assign tempB = '1;
    end
  endgenerate

  assign rawIn = {opMode, powerPermit, pcFailLoop, pcCableOk, magCableOk, tempB, tempLoopA};

  // Two-stage synchronizer and symmetric debounce per input
  generate
    for (genvar i = 0; i < NIN; i++) begin : gFilt
      logic          s1Q, s2Q, fQ;
      logic [CW-1:0] cQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          s1Q <= 1'b0;
          s2Q <= 1'b0;
          fQ  <= 1'b0;
          cQ  <= '0;
        end else begin
          s1Q <= rawIn[i];
          s2Q <= s1Q;
          if (s2Q == fQ) begin
            cQ <= '0;
          end else if (cQ == CW'(FILT_LEN - 1)) begin
            fQ <= s2Q;
            cQ <= '0;
          end else begin
            cQ <= cQ + 1'b1;
          end
        end
      end
      assign filt[i] = fQ;
    end
  endgenerate

  assign faultSeen = ~&filt[NLOOP-1:0];
  assign powerOk   = filt[NLOOP];
  assign opModeF   = filt[NLOOP+1];

  // Dump-wait hold timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tmr <= '0;
    else if (ctl.timerRun) tmr <= tmr + 1'b1;
    else                   tmr <= '0;
  end
  assign timerDone = (tmr == TW'(DUMP_DELAY - 1));

  assign beamOk   = ctl.beamGate & ~faultSeen;
  assign pcPermit = ctl.permitHold & powerOk;
  assign testOpen = ctl.testDrive ? (testReq & {NUM_MAG{~opMode}}) : '0;

endmodule

// File: rtl/mcis_control.sv
module mcis_control
  import mcis_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      faultSeen,
  input  logic      powerOk,
  input  logic      opModeF,
  input  logic      timerDone,
  input  logic      rearm,
  input  logic      testAny,
  output ctl_t      ctl,
  output seqState_t state
);

  seqState_t nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOCKOUT;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN: begin
        if (faultSeen)              nxt = ST_DUMPWAIT;
        else if (testAny && !opModeF) nxt = ST_SELFTEST;
      end
      ST_SELFTEST: begin
        if (faultSeen)              nxt = ST_DUMPWAIT;
        else if (!testAny || opModeF) nxt = ST_RUN;
      end
      ST_DUMPWAIT: begin
        if (timerDone)              nxt = ST_LOCKOUT;
      end
      ST_LOCKOUT: begin
        if (rearm && !faultSeen && powerOk) nxt = ST_RUN;
      end
      default: nxt = ST_LOCKOUT;
    endcase
  end

  always_comb begin
    ctl.timerRun   = (state == ST_DUMPWAIT);
    ctl.permitHold = (state != ST_LOCKOUT);
    ctl.beamGate   = (state == ST_RUN) || (state == ST_SELFTEST);
    ctl.testDrive  = (state == ST_SELFTEST);
  end

endmodule

// File: rtl/magnet_interlock_seq.sv
module magnet_interlock_seq
  import mcis_pkg::*;
#(
  parameter int NUM_MAG    = 4,
  parameter int FILT_LEN   = 16,
  parameter int DUMP_DELAY = 250_000_000,
  parameter bit DUAL_TEMP  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_MAG-1:0] tempLoopA,
  input  logic [NUM_MAG-1:0] tempLoopB,
  input  logic [NUM_MAG-1:0] magCableOk,
  input  logic               pcCableOk,
  input  logic               pcFailLoop,
  input  logic               powerPermit,
  input  logic               opMode,
  input  logic [NUM_MAG-1:0] testReq,
  input  logic               rearm,
  output logic               beamOk,
  output logic               pcPermit,
  output logic [NUM_MAG-1:0] testOpen,
  output logic [1:0]         stateOut
);

  ctl_t      ctl;
  seqState_t state;
  logic      faultSeen, powerOk, opModeF, timerDone;

  mcis_datapath #(
    .NUM_MAG(NUM_MAG), .FILT_LEN(FILT_LEN),
    .DUMP_DELAY(DUMP_DELAY), .DUAL_TEMP(DUAL_TEMP)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .tempLoopA(tempLoopA), .tempLoopB(tempLoopB), .magCableOk(magCableOk),
    .pcCableOk(pcCableOk), .pcFailLoop(pcFailLoop), .powerPermit(powerPermit),
    .opMode(opMode), .testReq(testReq), .ctl(ctl),
    .faultSeen(faultSeen), .powerOk(powerOk), .opModeF(opModeF),
    .timerDone(timerDone), .beamOk(beamOk), .pcPermit(pcPermit),
    .testOpen(testOpen)
  );

  mcis_control uCtl (
    .clk(clk), .rstN(rstN), .faultSeen(faultSeen), .powerOk(powerOk),
    .opModeF(opModeF), .timerDone(timerDone), .rearm(rearm),
    .testAny(|testReq), .ctl(ctl), .state(state)
  );

  assign stateOut = state;

endmodule

// File: rtl/mcis_checker.sv
module mcis_checker #(
  parameter int NUM_MAG    = 4,
  parameter int DUMP_DELAY = 250_000_000
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         stateOut,
  input logic               pcPermit,
  input logic               beamOk,
  input logic [NUM_MAG-1:0] testOpen,
  input logic               opMode,
  input logic               rearm
);

  localparam int TW = $clog2(DUMP_DELAY + 1) + 1;

  logic [TW-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               waitCnt <= '0;
    else if (stateOut == 2'd1) waitCnt <= waitCnt + 1'b1;
    else                     waitCnt <= '0;
  end

  a_r5_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd1) |-> (waitCnt < TW'(DUMP_DELAY)));

  a_r5_wait_exit: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd1 && waitCnt == TW'(DUMP_DELAY - 1)) |=> (stateOut == 2'd2));

  a_r6_lockout_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd2 && !rearm) |=> (stateOut == 2'd2));

  a_r7_lockout_no_permit: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd2) |-> (!pcPermit && !beamOk));

  a_r8_test_refused: assert property (@(posedge clk) disable iff (!rstN)
    opMode |-> (testOpen == '0));

  a_r8_test_only_selftest: assert property (@(posedge clk) disable iff (!rstN)
    (testOpen != '0) |-> (stateOut == 2'd3));

endmodule

bind magnet_interlock_seq mcis_checker #(
  .NUM_MAG(NUM_MAG), .DUMP_DELAY(DUMP_DELAY)
) uChk (
  .clk(clk), .rstN(rstN), .stateOut(stateOut), .pcPermit(pcPermit),
  .beamOk(beamOk), .testOpen(testOpen), .opMode(opMode), .rearm(rearm)
);

// File: tb/tb_magnet_interlock_seq.sv
module tb_magnet_interlock_seq;

  localparam int NM  = 3;
  localparam int FL  = 4;
  localparam int DL  = 40;

  // Table: group 0 tempA, 1 tempB, 2 magnet cable, 3 converter cable, 4 converter fail
  localparam int N_VEC = 6;
  localparam int unsigned VEC_GRP   [N_VEC] = '{0, 1, 2, 3, 4, 0};
  localparam int unsigned VEC_BIT   [N_VEC] = '{0, 2, 1, 0, 0, 2};
  localparam int unsigned VEC_HOLD  [N_VEC] = '{DL, DL, DL, DL, DL, DL};
  localparam int unsigned VEC_FINAL [N_VEC] = '{2, 2, 2, 2, 2, 2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NM-1:0] tA = '1, tB = '1, mc = '1, treq = '0;
  logic pcC = 1'b1, pcF = 1'b1, pwr = 1'b1, opm = 1'b0, rearm = 1'b0;
  logic beamOk, pcPermit;
  logic [NM-1:0] testOpen, tempA;
  logic [1:0] stateOut;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // The remote test physically opens the first chain of the selected magnet
  assign tempA = tA & ~testOpen;

  magnet_interlock_seq #(.NUM_MAG(NM), .FILT_LEN(FL), .DUMP_DELAY(DL), .DUAL_TEMP(1'b1)) dut (
    .clk(clk), .rstN(rstN), .tempLoopA(tempA), .tempLoopB(tB), .magCableOk(mc),
    .pcCableOk(pcC), .pcFailLoop(pcF), .powerPermit(pwr), .opMode(opm),
    .testReq(treq), .rearm(rearm), .beamOk(beamOk), .pcPermit(pcPermit),
    .testOpen(testOpen), .stateOut(stateOut)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseRearm();
    rearm = 1'b1;
    step(1);
    rearm = 1'b0;
  endtask

  task automatic setLoop(input int unsigned grp, input int unsigned b, input logic v);
    case (grp)
      0: tA[b] = v;
      1: tB[b] = v;
      2: mc[b] = v;
      3: pcC = v;
      default: pcF = v;
    endcase
  endtask

  initial begin
    step(3);
    check("R1 reset state", stateOut, 2);
    check("R1 reset permit", pcPermit, 0);
    check("R1 reset beamOk", beamOk, 0);
    rstN = 1'b1;
    step(10);
    check("R6 lockout holds without rearm", stateOut, 2);
    pcF = 1'b0;
    step(10);
    pulseRearm();
    check("R6 rearm ignored during fault", stateOut, 2);
    pcF = 1'b1;
    step(10);
    pulseRearm();
    check("R6 rearm enters run", stateOut, 0);
    check("R7 permit in run", pcPermit, 1);
    check("R4 beamOk in run", beamOk, 1);

    for (int v = 0; v < N_VEC; v++) begin
      setLoop(VEC_GRP[v], VEC_BIT[v], 1'b0);
      step(1 + FL);
      check("R3 fault not yet through filter", beamOk, 1);
      step(1);
      check("R2 R4 beamOk drops on fault", beamOk, 0);
      check("R4 permit kept in fault cycle", pcPermit, 1);
      step(int'(VEC_HOLD[v]));
      check("R5 still in dump-wait", stateOut, 1);
      check("R5 permit held during wait", pcPermit, 1);
      step(1);
      check("R5 lockout after hold", stateOut, int'(VEC_FINAL[v]));
      check("R5 permit removed", pcPermit, 0);
      setLoop(VEC_GRP[v], VEC_BIT[v], 1'b1);
      step(12);
      check("R6 lockout latched after recovery", stateOut, 2);
      pulseRearm();
      check("R6 rearm after recovery", stateOut, 0);
    end

    // Glitch one cycle shorter than the filter
    tA[1] = 1'b0;
    step(FL - 1);
    tA[1] = 1'b1;
    step(10);
    check("R3 short glitch ignored beamOk", beamOk, 1);
    check("R3 short glitch ignored state", stateOut, 0);

    // Powering permit loss
    pwr = 1'b0;
    step(3 + FL);
    check("R7 permit follows powerPermit", pcPermit, 0);
    check("R7 no dump on permit loss", beamOk, 1);
    check("R7 stays in run", stateOut, 0);
    pwr = 1'b1;
    step(3 + FL);
    check("R7 permit restored", pcPermit, 1);

    // Self-test refused in operation
    opm = 1'b1;
    step(10);
    treq = 3'b001;
    step(4);
    check("R8 test refused output", testOpen, 0);
    check("R8 test refused state", stateOut, 0);
    treq = '0;
    opm = 1'b0;
    step(10);

    // Raw operation mode cuts the test output at once
    treq = 3'b001;
    step(1);
    check("R8 self-test entered", stateOut, 3);
    check("R8 test output driven", testOpen, 1);
    opm = 1'b1;
    #1;
    check("R8 raw opMode clears output", testOpen, 0);
    step(3 + FL);
    check("R8 leaves self-test on opMode", stateOut, 0);
    check("R8 no trip from cut test", beamOk, 1);
    treq = '0;
    opm = 1'b0;
    step(10);

    // Self-test drives the trip chain
    treq = 3'b010;
    step(1);
    check("R9 self-test entered", stateOut, 3);
    check("R9 test opens magnet 1", testOpen, 2);
    step(2 + FL);
    check("R9 beamOk drops from test", beamOk, 0);
    step(1);
    check("R9 dump-wait after test", stateOut, 1);
    check("R9 test output released", testOpen, 0);
    treq = '0;
    step(DL);
    check("R9 lockout after test", stateOut, 2);
    check("R9 permit removed after test", pcPermit, 0);
    step(5);
    pulseRearm();
    check("R9 rearm after test", stateOut, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule